// File: doc/BRIEF.md
# Dictionary Macro Call/Return Unit

This unit gives a bytecode interpreter running on a small CPU a hardware call and return for dictionary macros. A dictionary macro is a bytecode value that stands for a stored sequence of bytecodes. Software first loads a lookup-table base register from the accumulator. When the interpreter meets a macro bytecode, it issues a single precall operation with the macro value in the accumulator. The unit then runs the whole call sequence on its own:

1. It saves the CPU program counter and the bytecode program counter (the JPC) into return registers.
2. It points the CPU PC at the table entry.
3. It reads the big-endian definition address from ROM and writes it into the JPC.
4. It puts the CPU PC back to its saved value.

The handler for the end-of-macro bytecode issues a restore operation. Restore copies the saved JPC back, so interpretation resumes at the bytecode that follows the macro bytecode. The interpreter increments the JPC before precall, so the saved value already points there.

There is one JPC return register, so macros cannot nest. Macro values are drawn from the bytecode values that the base instruction set leaves undefined. The table entry address is the table base plus the accumulator value. Any scaling of that value to the entry size is done by software.

The ROM read port is a valid/ready request channel plus a response channel. On the request channel, the unit holds `rom_req_valid_o` and a stable address until `rom_req_ready_i` is seen high at a clock edge. It keeps only one read outstanding. The response channel has no ready signal, because the unit always takes `rom_rsp_valid_i` while it waits for a byte and ignores it at any other time. The operation inputs and register write strobes are plain control pins.

Top module: `macro_call_unit`

## Requirements
- R1: A set-base operation while idle loads the table base from the accumulator at that clock edge. A precall accepted at the same edge still uses the previous base.
- R2: A precall accepted while idle captures `cpu_pc_i` and `jpc_i`. `busy_o` is high from the next cycle until the sequence ends. The unit never raises a PC write and a JPC write in the same cycle.
- R3: In the first cycle after precall is accepted, the unit writes the PC with base plus the accumulator's low VAL_W bits, zero-extended, added modulo 2^ADDR_W.
- R4: The unit then reads ADDR_W/8 bytes at the pointer and the following addresses, in rising address order, one request at a time. Each request stays valid with a stable address until ready is high. One cycle of waiting for the response follows each accepted request.
- R5: In the cycle after the last byte arrives, the unit writes the JPC with the bytes joined high byte first (the byte at the lowest address is the most significant).
- R6: In the cycle after the JPC write, the unit writes the PC with the captured PC. After that it is idle with `busy_o` low.
- R7: A restore accepted while idle writes the JPC with the saved JPC in the next cycle, with `busy_o` high for that one cycle only.
- R8: Operations that arrive while `busy_o` is high are ignored: no base change, no capture and no extra writes. While idle the unit drives no writes and no ROM request.
- R9: A second precall without a restore in between overwrites the saved JPC, so the next restore returns the second value.
- R10: After reset the unit is idle with no writes or requests. The base and both return registers are zero, so a restore straight after reset writes 0.
- R11: When precall and restore arrive together while idle, precall wins and the restore is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_set_base_i | input | 1 | Load the table base from the accumulator |
| op_precall_i | input | 1 | Start a macro call sequence |
| op_restore_i | input | 1 | Restore the saved JPC |
| acc_i | input | ADDR_W | Accumulator (base value, or macro value in its low VAL_W bits) |
| cpu_pc_i | input | ADDR_W | Current CPU program counter |
| jpc_i | input | ADDR_W | Current bytecode program counter |
| rom_req_valid_o | output | 1 | ROM read request valid |
| rom_req_ready_i | input | 1 | ROM read request accepted |
| rom_req_addr_o | output | ADDR_W | ROM byte address |
| rom_rsp_valid_i | input | 1 | ROM read data valid |
| rom_rsp_data_i | input | BYTE_W | ROM read data |
| pc_we_o | output | 1 | Write strobe for the CPU PC |
| pc_wd_o | output | ADDR_W | Value to write into the CPU PC |
| jpc_we_o | output | 1 | Write strobe for the JPC |
| jpc_wd_o | output | ADDR_W | Value to write into the JPC |
| busy_o | output | 1 | A sequence is in progress |

## Verification
Take a precall sampled at edge N. The table-pointer PC write is due in the cycle after N. The first ROM request follows one cycle later, and each byte costs its ready-wait cycles plus one response cycle. The JPC write comes one cycle after the last byte, and the PC restore one cycle after that. A restore sampled at edge N gives its JPC write, with busy, in the cycle after N.

The bench turns each accepted operation into a queue of expected per-cycle outputs. It spends ready-stall cycles from a known ready pattern while building that queue. It pops one entry at every falling edge, half a cycle after the edge that produced the outputs.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POINT,
    ST_REQ,
    ST_WAIT,
    ST_LOAD,
    ST_BACK,
    ST_REST
  } mc_state_e;
endpackage

// File: rtl/mc_base_reg.sv
module mc_base_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/mc_ret_regs.sv
module mc_ret_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] pc_d,
  input  logic [W-1:0] jpc_d,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] jpc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      jpc_q <= '0;
    end else if (cap) begin
      pc_q  <= pc_d;
      jpc_q <= jpc_d;
    end
  end
endmodule

// File: rtl/mc_seq.sv
module mc_seq
  import mcu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int VAL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_precall,
  input  logic              op_restore,
  input  logic [VAL_W-1:0]  mac_val,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] pc_ret,
  input  logic [ADDR_W-1:0] jpc_ret,
  output logic              cap,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data,
  output logic              pc_we,
  output logic [ADDR_W-1:0] pc_wd,
  output logic              jpc_we,
  output logic [ADDR_W-1:0] jpc_wd,
  output logic              busy
);
  localparam int NB = ADDR_W / BYTE_W;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  mc_state_e         st_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] def_q;
  logic [IW-1:0]     idx_q;
  logic              take_call, take_ret;

  assign take_call = (st_q == ST_IDLE) && op_precall;
  assign take_ret  = (st_q == ST_IDLE) && !op_precall && op_restore;
  assign cap       = take_call;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
      def_q <= '0;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (take_call) begin
            ptr_q <= base + ADDR_W'(mac_val);
            idx_q <= '0;
            st_q  <= ST_POINT;
          end else if (take_ret) begin
            st_q <= ST_REST;
          end
        end
        ST_POINT: st_q <= ST_REQ;
        ST_REQ:   if (req_ready) st_q <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_valid) begin
            if (NB > 1) def_q <= {def_q[ADDR_W-BYTE_W-1:0], rsp_data};
            else        def_q <= ADDR_W'(rsp_data);
            if (idx_q == IW'(NB - 1)) begin
              st_q <= ST_LOAD;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_REQ;
            end
          end
        end
        ST_LOAD: st_q <= ST_BACK;
        ST_BACK: st_q <= ST_IDLE;
        ST_REST: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (st_q != ST_IDLE);
    pc_we     = (st_q == ST_POINT) || (st_q == ST_BACK);
    pc_wd     = (st_q == ST_POINT) ? ptr_q : pc_ret;
    jpc_we    = (st_q == ST_LOAD) || (st_q == ST_REST);
    jpc_wd    = (st_q == ST_LOAD) ? def_q : jpc_ret;
    req_valid = (st_q == ST_REQ);
    req_addr  = ptr_q + ADDR_W'(idx_q);
  end
endmodule

// File: rtl/macro_call_unit.sv
module macro_call_unit #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int VAL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_set_base_i,
  input  logic              op_precall_i,
  input  logic              op_restore_i,
  input  logic [ADDR_W-1:0] acc_i,
  input  logic [ADDR_W-1:0] cpu_pc_i,
  input  logic [ADDR_W-1:0] jpc_i,
  output logic              rom_req_valid_o,
  input  logic              rom_req_ready_i,
  output logic [ADDR_W-1:0] rom_req_addr_o,
  input  logic              rom_rsp_valid_i,
  input  logic [BYTE_W-1:0] rom_rsp_data_i,
  output logic              pc_we_o,
  output logic [ADDR_W-1:0] pc_wd_o,
  output logic              jpc_we_o,
  output logic [ADDR_W-1:0] jpc_wd_o,
  output logic              busy_o
);
  logic [ADDR_W-1:0] base_q, pc_ret_q, jpc_ret_q;
  logic              cap;

  mc_base_reg #(.W(ADDR_W)) u_base (
    .clk(clk), .rst_n(rst_n), .load(op_set_base_i && !busy_o),
    .d(acc_i), .q(base_q)
  );

  mc_ret_regs #(.W(ADDR_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .cap(cap), .pc_d(cpu_pc_i), .jpc_d(jpc_i),
    .pc_q(pc_ret_q), .jpc_q(jpc_ret_q)
  );

  mc_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .VAL_W(VAL_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .op_precall(op_precall_i), .op_restore(op_restore_i),
    .mac_val(acc_i[VAL_W-1:0]), .base(base_q),
    .pc_ret(pc_ret_q), .jpc_ret(jpc_ret_q), .cap(cap),
    .req_valid(rom_req_valid_o), .req_ready(rom_req_ready_i),
    .req_addr(rom_req_addr_o), .rsp_valid(rom_rsp_valid_i),
    .rsp_data(rom_rsp_data_i),
    .pc_we(pc_we_o), .pc_wd(pc_wd_o), .jpc_we(jpc_we_o), .jpc_wd(jpc_wd_o),
    .busy(busy_o)
  );
endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rom_req_valid_o,
  input logic              rom_req_ready_i,
  input logic [ADDR_W-1:0] rom_req_addr_o,
  input logic              rom_rsp_valid_i,
  input logic              pc_we_o,
  input logic              jpc_we_o,
  input logic              busy_o
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req_valid_o && !rom_req_ready_i |=> rom_req_valid_o && $stable(rom_req_addr_o));

  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we_o |-> !jpc_we_o);

  assert_first_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (pc_we_o != jpc_we_o));

  assert_restore_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    jpc_we_o && $past(rom_rsp_valid_i) |=> pc_we_o);

  assert_end_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we_o && $past(jpc_we_o) |=> !busy_o);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !pc_we_o && !jpc_we_o && !rom_req_valid_o);
endmodule

bind macro_call_unit mc_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rom_req_valid_o(rom_req_valid_o), .rom_req_ready_i(rom_req_ready_i),
  .rom_req_addr_o(rom_req_addr_o), .rom_rsp_valid_i(rom_rsp_valid_i),
  .pc_we_o(pc_we_o), .jpc_we_o(jpc_we_o), .busy_o(busy_o)
);

// File: tb/test_macro_call_unit.sv
module test_macro_call_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_set_base = 1'b0, op_precall = 1'b0, op_restore = 1'b0;
  logic [15:0] acc = '0, cpu_pc = '0, jpc = '0;
  logic        req_valid, req_ready, rsp_valid = 1'b0;
  logic [15:0] req_addr;
  logic [7:0]  rsp_data = '0;
  logic        pc_we, jpc_we, busy;
  logic [15:0] pc_wd, jpc_wd;

  int cyc = 0, checks = 0, fails = 0, idle_tag = 10;
  bit ready_mode = 0;
  logic [15:0] m_base = '0, m_jpc_ret = '0;

  typedef struct {
    bit b; bit pw; logic [15:0] pd; bit jw; logic [15:0] jd;
    bit rv; logic [15:0] ra; int r;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  assign req_ready = ready_mode ? cyc[0] : 1'b1;

  function automatic logic [7:0] rom_byte(logic [15:0] a);
    return 8'(a * 7 + 3) ^ a[15:8];
  endfunction

  always @(posedge clk) begin
    rsp_valid <= req_valid && req_ready;
    rsp_data  <= rom_byte(req_addr);
  end

  macro_call_unit i_macro_call_unit (
    .clk(clk), .rst_n(rst_n), .op_set_base_i(op_set_base),
    .op_precall_i(op_precall), .op_restore_i(op_restore), .acc_i(acc),
    .cpu_pc_i(cpu_pc), .jpc_i(jpc), .rom_req_valid_o(req_valid),
    .rom_req_ready_i(req_ready), .rom_req_addr_o(req_addr),
    .rom_rsp_valid_i(rsp_valid), .rom_rsp_data_i(rsp_data),
    .pc_we_o(pc_we), .pc_wd_o(pc_wd), .jpc_we_o(jpc_we), .jpc_wd_o(jpc_wd),
    .busy_o(busy)
  );

  task automatic push(bit b, bit pw, logic [15:0] pd, bit jw, logic [15:0] jd,
                      bit rv, logic [15:0] ra, int r);
    exp_t e;
    e.b = b; e.pw = pw; e.pd = pd; e.jw = jw; e.jd = jd; e.rv = rv; e.ra = ra; e.r = r;
    exp_q.push_back(e);
  endtask

  task automatic compare();
    exp_t e;
    bit bad;
    if (exp_q.size() > 0) e = exp_q.pop_front();
    else begin
      e.b = 0; e.pw = 0; e.pd = 0; e.jw = 0; e.jd = 0; e.rv = 0; e.ra = 0; e.r = idle_tag;
    end
    bad = (busy !== e.b) || (pc_we !== e.pw) || (jpc_we !== e.jw) || (req_valid !== e.rv)
       || (e.pw && pc_wd !== e.pd) || (e.jw && jpc_wd !== e.jd) || (e.rv && req_addr !== e.ra);
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL R%0d cyc %0d: actual busy=%b pcwe=%b pc=%h jwe=%b jpc=%h rv=%b ra=%h expected busy=%b pcwe=%b pc=%h jwe=%b jpc=%h rv=%b ra=%h",
               e.r, cyc, busy, pc_we, pc_wd, jpc_we, jpc_wd, req_valid, req_addr,
               e.b, e.pw, e.pd, e.jw, e.jd, e.rv, e.ra);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    compare();
  endtask

  function automatic bit rdy(int t);
    return ready_mode ? t[0] : 1'b1;
  endfunction

  // Builds the expected output stream of one precall; the slot after the current one is the first
  task automatic gen_call(logic [15:0] val, logic [15:0] pc, logic [15:0] jv);
    logic [15:0] ptr = m_base + val;
    logic [15:0] d = '0;
    int t = cyc + 1;
    push(1, 1, ptr, 0, 0, 0, 0, 3); t++;                    // R3 table pointer write
    for (int b = 0; b < 2; b++) begin
      bit got = 0;
      while (!got) begin
        push(1, 0, 0, 0, 0, 1, 16'(ptr + b), 4); got = rdy(t); t++;   // R4 request held
      end
      push(1, 0, 0, 0, 0, 0, 0, 4); t++;                    // R4 response cycle
      d = {d[7:0], rom_byte(16'(ptr + b))};
    end
    push(1, 0, 0, 1, d, 0, 0, 5);                           // R5 definition into JPC
    push(1, 1, pc, 0, 0, 0, 0, 6);                          // R6 PC restored
    m_jpc_ret = jv;
  endtask

  // Applies one slot of operations; the model reacts only when the unit is idle (R8)
  task automatic issue(bit sb, bit pc_op, bit rs, logic [15:0] a, logic [15:0] p, logic [15:0] j);
    op_set_base = sb; op_precall = pc_op; op_restore = rs; acc = a; cpu_pc = p; jpc = j;
    if (exp_q.size() == 0) begin
      if (pc_op) gen_call({8'h00, a[7:0]}, p, j);           // R11 precall wins
      else if (rs) push(1, 0, 0, 1, m_jpc_ret, 0, 0, 7);    // R7 restore
      if (sb) m_base = a;                                   // R1 new base after this edge
    end
    tick();
    op_set_base = 0; op_precall = 0; op_restore = 0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) tick();
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    idle_tag = 8;
    // R10 restore after reset gives zero
    issue(0, 0, 1, 16'h0, 16'h0, 16'h0); drain();
    // R1 set base, R2..R6 full call with free-running ready
    issue(1, 0, 0, 16'h1200, 0, 0);
    issue(0, 1, 0, 16'h0005, 16'h0345, 16'h0777); drain();
    issue(0, 0, 1, 0, 0, 0); drain();                       // R7
    // R4 back-pressure, R8 operations during busy ignored
    ready_mode = 1;
    issue(0, 1, 0, 16'h0042, 16'h0100, 16'h0A0A);
    tick();
    issue(1, 1, 1, 16'h00EE, 16'h0BAD, 16'h0BAD);           // R8 ignored
    tick();
    issue(0, 0, 1, 0, 0, 0);                                // R8 ignored
    drain();
    issue(0, 0, 1, 0, 0, 0); drain();                       // R7 returns 0x0A0A
    // R9 second precall overwrites saved JPC
    issue(0, 1, 0, 16'h0010, 16'h0200, 16'h1111); drain();
    issue(0, 1, 0, 16'h0011, 16'h0300, 16'h2222); drain();
    issue(0, 0, 1, 0, 0, 0); drain();                       // R9 expects 0x2222
    // R11 precall and restore together
    ready_mode = 0;
    issue(0, 1, 1, 16'h0033, 16'h0400, 16'h3333); drain();
    // R1 set base together with precall uses old base
    issue(1, 1, 0, 16'hFFF8, 16'h0500, 16'h4444); drain();
    // R3 pointer wraps modulo 2^16, upper accumulator bits ignored
    issue(0, 1, 0, 16'hABFF, 16'h0600, 16'h5555); drain();
    issue(0, 0, 1, 0, 0, 0); drain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule